// File: doc/BRIEF.md
# Log-Step Chain Reduction Adder

This block adds up N words held side by side in a linear chain, where N is a power of two. It uses recursive doubling. A start pulse captures all N words in parallel. On each of the next log2(N) clock edges, every chain position adds the value that sits 2^k places further along the chain. Here k is the step number. Positions past the end of the chain supply zero. After the last step the first position holds the grand total, and every position i holds the sum of the words from i to the end of the chain.

A client drives the N input words together with a one-cycle start pulse and then waits for the done flag. The total is presented on its own output. The whole chain is also visible at all times, so a client can use the suffix sums or watch the intermediate windows. Each accumulator is log2(N) bits wider than an input word, so no sum can wrap. A start that arrives while a reduction is running has no effect.

Top module: `log_step_reducer`

## Requirements
- R1: On the clock edge where start is high and no reduction is running, every chain position i is loaded with input word i (bits i*W upward of the load bus), zero-extended to the accumulator width.
- R2: On the k-th edge after the load (k counting from 1), each position i takes its own value plus the value of position i+2^(k-1). After s steps, position i therefore holds the sum of input words i to i+2^s-1.
- R3: A partner position at or beyond N contributes zero, so the last chain position keeps its loaded value for the whole reduction.
- R4: After log2(N) steps, position i holds the sum of input words i to N-1, and the total output equals the sum of all N words.
- R5: Done is low during the load cycle and during every step. It is high from the cycle after the final step until the next accepted start, and that start's load edge clears it.
- R6: Each accumulator is W+log2(N) bits wide. With every input at its maximum value, the total is N*(2^W-1) with no wrap.
- R7: A start pulse during a running reduction, including one on the final step, changes neither the result nor the cycle in which done rises.
- R8: After a synchronous active-low reset, every chain position, the total and done are zero.
- R9: While done is high and no start arrives, the total and the chain hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to load the input words and begin |
| load_data | input | N*W | N input words; word i occupies bits [i*W +: W] |
| total | output | W+log2(N) | Sum held by chain position 0 |
| done | output | 1 | High once the reduction has finished, until the next accepted start |
| chain_out | output | N*(W+log2(N)) | Live accumulator of every chain position; position i at [i*ACC_W +: ACC_W] |

## Verification
The hardest case to reach from the ports is a start pulse that lands inside a running reduction, and above all one that lands on the final step edge. On that edge the sequencer is about to return to idle, so an off-by-one in its state handling would accept the start. The bench runs a full reduction and raises start, with different data, on a chosen step number: once mid-run and once on exactly the last edge. It then checks that the result, the suffix sums and the cycle in which done rises all match the first data set. All chain positions are compared against window sums after every step, so the distance schedule and the zero fill past the end are checked one step at a time rather than only through the final total.

// File: rtl/rdc_pkg.sv
// Package: shared types for the log-step chain reduction adder.
// Assumes nothing beyond a two-state sequencer.
package rdc_pkg;
    typedef enum logic {
        RDC_IDLE = 1'b0,
        RDC_RUN  = 1'b1
    } rdc_state_e;
endpackage

// File: rtl/rdc_sequencer.sv
// Module: rdc_sequencer
// Counts the log2(N) reduction steps after an accepted start. It emits a
// load strobe and a per-step advance strobe, and holds done after the last
// step. Assumes LOG_N >= 1. Start is ignored while a run is in progress.
module rdc_sequencer
    import rdc_pkg::*;
#(
    parameter int LOG_N  = 4,
    parameter int STEP_W = $clog2(LOG_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              load,
    output logic              advance,
    output logic [STEP_W-1:0] step_idx,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LOG_N - 1);

    rdc_state_e state;

    // Strobes decoded from the current state.
    always_comb begin
        load    = (state == RDC_IDLE) && start;
        advance = (state == RDC_RUN);
    end

    // Step counter, run state and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RDC_IDLE;
            step_idx <= '0;
            done     <= 1'b0;
        end else begin
            case (state)
                RDC_IDLE: begin
                    if (start) begin
                        state    <= RDC_RUN;
                        step_idx <= '0;
                        done     <= 1'b0;
                    end
                end
                RDC_RUN: begin
                    if (step_idx == LAST_STEP) begin
                        state    <= RDC_IDLE;
                        step_idx <= '0;
                        done     <= 1'b1;
                    end else begin
                        step_idx <= step_idx + 1'b1;
                    end
                end
                default: state <= RDC_IDLE;
            endcase
        end
    end

    // Done may only rise right after the final step of a run.
    assert_done_after_last_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state == RDC_RUN && step_idx == LAST_STEP));

    // A start during a non-final step leaves the run going.
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RDC_RUN && start && step_idx != LAST_STEP) |=> (state == RDC_RUN && !done));
endmodule

// File: rtl/rdc_partner_sel.sv
// Module: rdc_partner_sel
// For chain position IDX, picks the value 2^step places further along the
// chain, or zero if that place lies past the end. Assumes N is a power of two.
module rdc_partner_sel #(
    parameter int N      = 16,
    parameter int ACC_W  = 12,
    parameter int LOG_N  = 4,
    parameter int STEP_W = 3,
    parameter int IDX    = 0
) (
    input  logic [STEP_W-1:0] step_idx,
    input  logic [ACC_W-1:0]  chain [N],
    output logic [ACC_W-1:0]  partner
);
    // Distance multiplexer with zero fill past the chain end.
    always_comb begin
        partner = '0;
        for (int k = 0; k < LOG_N; k++) begin
            if (step_idx == STEP_W'(k) && (IDX + (1 << k)) < N) begin
                partner = chain[(IDX + (1 << k)) % N];
            end
        end
    end
endmodule

// File: rtl/rdc_lane.sv
// Module: rdc_lane
// One chain accumulator. It loads a zero-extended input word, then adds the
// partner value on each advance strobe. Assumes load and advance never coincide.
module rdc_lane #(
    parameter int W     = 8,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [W-1:0]     load_val,
    input  logic [ACC_W-1:0] partner,
    output logic [ACC_W-1:0] acc
);
    // Accumulator register: load, add, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= {{(ACC_W - W){1'b0}}, load_val};
        end else if (advance) begin
            acc <= acc + partner;
        end
    end

    // The sequencer must never load and advance together.
    assert_no_load_during_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));

    // A step never wraps the accumulator.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (acc >= $past(acc)));
endmodule

// File: rtl/log_step_reducer.sv
// Module: log_step_reducer (top)
// Sums N words by recursive doubling over a linear chain, updating every
// position in parallel once per clock. Assumes N is a power of two, N >= 2.
module log_step_reducer #(
    parameter int N = 16,
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [N*W-1:0]             load_data,
    output logic [W+$clog2(N)-1:0]     total,
    output logic                       done,
    output logic [N*(W+$clog2(N))-1:0] chain_out
);
    localparam int LOG_N  = $clog2(N);
    localparam int ACC_W  = W + LOG_N;
    localparam int STEP_W = $clog2(LOG_N + 1);

    logic              load;
    logic              advance;
    logic [STEP_W-1:0] step_idx;
    logic [ACC_W-1:0]  chain [N];

    rdc_sequencer #(.LOG_N(LOG_N), .STEP_W(STEP_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .advance  (advance),
        .step_idx (step_idx),
        .done     (done)
    );

    for (genvar i = 0; i < N; i++) begin : g_pos
        logic [ACC_W-1:0] partner;

        rdc_partner_sel #(
            .N(N), .ACC_W(ACC_W), .LOG_N(LOG_N), .STEP_W(STEP_W), .IDX(i)
        ) u_sel (
            .step_idx (step_idx),
            .chain    (chain),
            .partner  (partner)
        );

        rdc_lane #(.W(W), .ACC_W(ACC_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .advance  (advance),
            .load_val (load_data[i*W +: W]),
            .partner  (partner),
            .acc      (chain[i])
        );

        assign chain_out[i*ACC_W +: ACC_W] = chain[i];
    end

    assign total = chain[0];

    // The last position has no partner inside the chain.
    assert_tail_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> $stable(chain[N-1]));

    // Once finished, the total holds until a new start.
    assert_total_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(total));
endmodule

// File: tb/log_step_reducer_bench.sv
// Bench: directed scenarios, each task checks its own results.
module log_step_reducer_bench;
    localparam int N     = 16;
    localparam int W     = 8;
    localparam int LOG_N = $clog2(N);
    localparam int ACC_W = W + LOG_N;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [N*W-1:0]       load_data = '0;
    logic [ACC_W-1:0]     total;
    logic                 done;
    logic [N*ACC_W-1:0]   chain_out;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;

    log_step_reducer #(.N(N), .W(W)) u_log_step_reducer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_data (load_data),
        .total     (total),
        .done      (done),
        .chain_out (chain_out)
    );

    always #2 clk = ~clk;  // 250 MHz

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint pos_val(input int i);
        return longint'(chain_out[i*ACC_W +: ACC_W]);
    endfunction

    // Sum of words i .. i+len-1, with zero past the end.
    function automatic longint win_sum(input logic [W-1:0] v [N], input int i, input int len);
        longint s = 0;
        for (int j = i; j < i + len && j < N; j++) s += longint'(v[j]);
        return s;
    endfunction

    // Full run; poke_step > 0 raises start with other data before that step edge.
    task automatic run_case(input string name, input logic [W-1:0] v [N], input int poke_step);
        @(negedge clk);
        for (int i = 0; i < N; i++) load_data[i*W +: W] = v[i];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < N; i++) chk("R1", pos_val(i), longint'(v[i]), {name, " load"});
        chk("R5", longint'(done), 0, {name, " done low after load"});
        for (int s = 1; s <= LOG_N; s++) begin
            if (s == poke_step) begin
                for (int i = 0; i < N; i++) load_data[i*W +: W] = ~v[i];
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < N - 1; i++)
                chk((s == LOG_N) ? "R4" : "R2", pos_val(i), win_sum(v, i, 1 << s), {name, " window"});
            chk("R3", pos_val(N-1), longint'(v[N-1]), {name, " tail"});
            chk((poke_step > 0) ? "R7" : "R5", longint'(done), (s == LOG_N) ? 1 : 0, {name, " done timing"});
        end
        chk("R4", longint'(total), win_sum(v, 0, N), {name, " total"});
    endtask

    task automatic t_reset;
        for (int i = 0; i < N; i++) chk("R8", pos_val(i), 0, "reset chain");
        chk("R8", longint'(total), 0, "reset total");
        chk("R8", longint'(done), 0, "reset done");
    endtask

    task automatic t_ramp;
        logic [W-1:0] v [N];
        for (int i = 0; i < N; i++) v[i] = W'(i + 1);
        run_case("ramp", v, 0);
    endtask

    task automatic t_max;
        logic [W-1:0] v [N];
        for (int i = 0; i < N; i++) v[i] = '1;
        run_case("max", v, 0);
        chk("R6", longint'(total), longint'(N) * ((1 << W) - 1), "max total no wrap");
    endtask

    task automatic t_busy_mid;
        logic [W-1:0] v [N];
        for (int i = 0; i < N; i++) v[i] = W'((i * 37 + 11) % 251);
        run_case("busy_mid", v, 2);
    endtask

    task automatic t_busy_last;
        logic [W-1:0] v [N];
        for (int i = 0; i < N; i++) v[i] = W'((i % 3 == 0) ? 200 : i * 5);
        run_case("busy_last", v, LOG_N);
    endtask

    task automatic t_hold;
        longint t0 = longint'(total);
        longint c0 = pos_val(5);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk("R9", longint'(total), t0, "total held");
            chk("R9", pos_val(5), c0, "chain held");
            chk("R5", longint'(done), 1, "done held");
        end
    endtask

    task automatic t_sparse;
        logic [W-1:0] v [N];
        for (int i = 0; i < N; i++) v[i] = '0;
        v[0] = 8'd3; v[N-1] = 8'd250; v[N/2] = 8'd17;
        run_case("sparse", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ramp();
        t_hold();
        t_max();
        t_busy_mid();
        t_busy_last();
        t_hold();
        t_sparse();
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule